// File: doc/BRIEF.md
# Single-Bit Stable Partition Stage for Radix Sorting

This block carries out one pass of a least-significant-digit radix sort. It accepts a block of up to `N` keys, each with an optional payload, over a valid/ready stream that has a last marker. A run-time bit index picks one key bit. The block then sends the same elements back out, reordered so that every key whose chosen bit is 0 comes before every key whose chosen bit is 1. Inside each of the two groups, the order in which elements arrived is kept.

Destinations come from a single exclusive prefix count of the inverted bit. While an element arrives, the block records how many zero-bit elements came before it (`f`). After the last element, the total number of zero-bit elements is known. A zero-bit element then goes to slot `f`. A one-bit element at input position `i` goes to slot `i - f + zeros_total`.

One scatter cycle places every element into an output buffer, which is then drained in order. A full sort of k-bit keys runs k such passes, starting at bit 0. An outside controller sequences those passes.

Top module: `radix_split`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: `bit_sel` is sampled when the first element of a block is accepted. Changes to `bit_sel` during later elements of the same block do not affect the output order.
- R3: In the output of a block, no element whose selected key bit is 1 comes before an element whose selected bit is 0.
- R4: The output is stable: within the zero group, and within the one group, elements leave in the order they arrived.
- R5: Each payload is output on the same beat as the key it arrived with.
- R6: A block produces exactly as many output beats as it accepted. `out_last` is 1 on the final beat only, and no further beat follows it.
- R7: A block ends on an accepted beat with `in_last` = 1, or on the `N`-th accepted beat, whichever comes first. `in_ready` is 0 in the cycle after a block ends.
- R8: `in_ready` stays 0 from the end of a block until its last output beat is taken. While `out_valid` is 1 and `out_ready` is 0, `out_key`, `out_pay` and `out_last` hold steady.
- R9: Keys 4,7,2,6,3,5,1,0 (in arrival order), split on bit 0, come out as 4,2,6,0,7,3,5,1.
- R10: A block in which every selected bit is equal (all 0 or all 1) comes out in arrival order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_sel | input | $clog2(KEY_W) | Index of the key bit to split on, taken at the first beat of a block |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can accept an input beat |
| in_key | input | KEY_W | Input key |
| in_pay | input | PAY_W | Input payload |
| in_last | input | 1 | Marks the final beat of a block |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_key | output | KEY_W | Output key |
| out_pay | output | PAY_W | Output payload |
| out_last | output | 1 | Marks the final output beat of a block |

## Verification
The bench sweeps every bit index against every block length from 1 to `N`. This catches an off-by-one in the one-group destination formula, which would collide two elements or leave a slot empty and corrupt the order. Single-element blocks and blocks whose selected bits are all 0 or all 1 are exercised, because a wrong zero total there sends elements past the block end. One block moves `bit_sel` after its first beat: a design that sampled the index on every beat would mix two partitions. Another block never raises `in_last`, and the bench checks that the block closes itself at `N`. Output backpressure checks that data holds and that no beat is lost or repeated.

// File: rtl/radix_split.sv
module radix_split #(
  parameter int KEY_W = 8,
  parameter int PAY_W = 8,
  parameter int N     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(KEY_W)-1:0]   bit_sel,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [KEY_W-1:0]           in_key,
  input  logic [PAY_W-1:0]           in_pay,
  input  logic                       in_last,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [KEY_W-1:0]           out_key,
  output logic [PAY_W-1:0]           out_pay,
  output logic                       out_last
);
  localparam int BW = $clog2(KEY_W);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(N + 1);

  typedef enum logic [1:0] {S_FILL, S_SCAT, S_DRAIN} state_t;
  state_t state;

  logic [KEY_W-1:0] k_buf [N];
  logic [PAY_W-1:0] p_buf [N];
  logic [CW-1:0]    f_buf [N];
  logic [N-1:0]     b_buf;
  logic [KEY_W-1:0] ok_buf [N];
  logic [PAY_W-1:0] op_buf [N];
  logic [CW-1:0]    dst [N];

  logic [CW-1:0] cnt, zeros, rd;
  logic [BW-1:0] bsel_q;

  wire [BW-1:0] bsel_now = (cnt == '0) ? bit_sel : bsel_q;
  wire          in_bit   = in_key[bsel_now];
  wire          in_fire  = in_valid && in_ready;
  wire          out_fire = out_valid && out_ready;
  wire          blk_end  = in_last || (cnt == CW'(N - 1));
  wire [IW-1:0] wr_idx   = IW'(cnt);
  wire [IW-1:0] rd_idx   = IW'(rd);

  assign in_ready  = (state == S_FILL);
  assign out_valid = (state == S_DRAIN);
  assign out_key   = ok_buf[rd_idx];
  assign out_pay   = op_buf[rd_idx];
  assign out_last  = (rd == cnt - CW'(1));

  always_comb begin
    for (int i = 0; i < N; i++)
      dst[i] = b_buf[i] ? (CW'(i) - f_buf[i] + zeros) : f_buf[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_FILL;
      cnt    <= '0;
      zeros  <= '0;
      rd     <= '0;
      bsel_q <= '0;
    end else begin
      case (state)
        S_FILL: if (in_fire) begin
          if (cnt == '0) bsel_q <= bit_sel;
          cnt   <= cnt + CW'(1);
          zeros <= zeros + CW'(!in_bit);
          if (blk_end) state <= S_SCAT;
        end
        S_SCAT: begin
          rd    <= '0;
          state <= S_DRAIN;
        end
        S_DRAIN: if (out_fire) begin
          rd <= rd + CW'(1);
          if (out_last) begin
            state <= S_FILL;
            cnt   <= '0;
            zeros <= '0;
          end
        end
        default: state <= S_FILL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_FILL && in_fire) begin
      k_buf[wr_idx] <= in_key;
      p_buf[wr_idx] <= in_pay;
      f_buf[wr_idx] <= zeros;
      b_buf[wr_idx] <= in_bit;
    end
    if (state == S_SCAT) begin
      for (int p = 0; p < N; p++)
        for (int i = 0; i < N; i++)
          if (CW'(i) < cnt && dst[i] == CW'(p)) begin
            ok_buf[p] <= k_buf[i];
            op_buf[p] <= p_buf[i];
          end
    end
  end
endmodule

// File: rtl/radix_split_chk.sv
module radix_split_chk #(
  parameter int KEY_W = 8,
  parameter int PAY_W = 8,
  parameter int N     = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic [$clog2(KEY_W)-1:0] bit_sel,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic [KEY_W-1:0]         in_key,
  input logic [PAY_W-1:0]         in_pay,
  input logic                     in_last,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [KEY_W-1:0]         out_key,
  input logic [PAY_W-1:0]         out_pay,
  input logic                     out_last
);
  localparam int BW = $clog2(KEY_W);
  localparam int CW = $clog2(N + 1);

  logic          first_c, seen_one;
  logic [BW-1:0] bsel_c;
  logic [CW-1:0] icnt, ocnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_c  <= 1'b1;
      seen_one <= 1'b0;
      bsel_c   <= '0;
      icnt     <= '0;
      ocnt     <= '0;
    end else begin
      if (in_valid && in_ready) begin
        if (first_c) bsel_c <= bit_sel;
        first_c <= in_last || (icnt == CW'(N - 1));
        icnt    <= icnt + CW'(1);
      end
      if (out_valid && out_ready) begin
        if (out_last) begin
          ocnt     <= '0;
          icnt     <= '0;
          seen_one <= 1'b0;
        end else begin
          ocnt     <= ocnt + CW'(1);
          seen_one <= seen_one || out_key[bsel_c];
        end
      end
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !out_valid));

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_key) && $stable(out_pay) && $stable(out_last)));

  // R3
  group_order_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && seen_one) |-> out_key[bsel_c]);

  // R6
  beat_count_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |-> ((ocnt + CW'(1)) == icnt));

  // R7
  block_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> (icnt < CW'(N)));
endmodule

bind radix_split radix_split_chk #(.KEY_W(KEY_W), .PAY_W(PAY_W), .N(N)) u_chk (.*);

// File: tb/radix_split_tb.sv
module radix_split_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] bit_sel;
  logic       in_valid, in_ready, in_last;
  logic [7:0] in_key, in_pay;
  logic       out_valid, out_ready, out_last;
  logic [7:0] out_key, out_pay;

  int vectors = 0;
  int misses  = 0;
  logic [7:0] kk [N];
  logic [7:0] pp [N];
  logic [7:0] ek [N];
  logic [7:0] ep [N];

  always #(CLK_PERIOD / 2) clk = ~clk;

  radix_split #(.KEY_W(8), .PAY_W(8), .N(N)) u_dut (
    .clk(clk), .rst(rst), .bit_sel(bit_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_key(in_key), .in_pay(in_pay), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_key(out_key), .out_pay(out_pay), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // mode 0: arithmetic keys, 1: fixed example, 2: selected bit all 0, 3: all 1
  task automatic run_block(input int len, input int bs, input int mode, input int seed,
                           input bit bump, input bit no_last, input bit bp);
    int j;
    int cyc;
    int got;
    for (int i = 0; i < len; i++) begin
      case (mode)
        1:       kk[i] = 8'(7 - ((i * 5 + 3) % 8));
        2:       kk[i] = 8'((seed * 29 + i * 83 + 7) & ~(1 << bs));
        3:       kk[i] = 8'((seed * 29 + i * 83 + 7) | (1 << bs));
        default: kk[i] = 8'(seed * 29 + i * 83 + 7);
      endcase
      pp[i] = 8'(seed * 8 + i);
    end
    if (mode == 1) begin
      kk[0] = 4; kk[1] = 7; kk[2] = 2; kk[3] = 6;
      kk[4] = 3; kk[5] = 5; kk[6] = 1; kk[7] = 0;
    end
    j = 0;
    for (int i = 0; i < len; i++)
      if (!kk[i][bs]) begin ek[j] = kk[i]; ep[j] = pp[i]; j++; end
    for (int i = 0; i < len; i++)
      if (kk[i][bs]) begin ek[j] = kk[i]; ep[j] = pp[i]; j++; end

    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      check(in_ready == 1'b1, "R8 ready during fill", int'(in_ready), 1);
      bit_sel  = (bump && i > 0) ? 3'(bs ^ 5) : 3'(bs);
      in_valid = 1'b1;
      in_key   = kk[i];
      in_pay   = pp[i];
      in_last  = !no_last && (i == len - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    check(in_ready == 1'b0, no_last ? "R7 forced end at N" : "R7 end on last", int'(in_ready), 0);

    got = 0;
    cyc = 0;
    while (got < len) begin
      @(negedge clk);
      out_ready = bp ? ((cyc % 3) != 1) : 1'b1;
      cyc++;
      if (out_valid) check(in_ready == 1'b0, "R8 no input while draining", int'(in_ready), 0);
      if (out_valid && out_ready) begin
        if (mode == 1)
          check(out_key == ek[got], "R9 example order", int'(out_key), int'(ek[got]));
        else if (mode >= 2)
          check(out_key == ek[got], "R10 uniform bit keeps order", int'(out_key), int'(ek[got]));
        else
          check(out_key == ek[got], bump ? "R2 index held in block" : "R3 R4 partition order",
                int'(out_key), int'(ek[got]));
        check(out_pay == ep[got], "R5 payload follows key", int'(out_pay), int'(ep[got]));
        check(out_last == (got == len - 1), "R6 last marker", int'(out_last), int'(got == len - 1));
        got++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R6 no extra beat", int'(out_valid), 0);
    check(in_ready == 1'b1, "R8 ready after drain", int'(in_ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rst = 1'b1;
    bit_sel = '0; in_valid = 1'b0; in_key = '0; in_pay = '0; in_last = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 reset idle", int'(out_valid), 0);

    run_block(8, 0, 1, 0, 1'b0, 1'b0, 1'b0);
    for (int bs = 0; bs < 8; bs++)
      for (int len = 1; len <= N; len++)
        run_block(len, bs, 0, bs * 8 + len, 1'b0, 1'b0, (len % 2) == 1);
    run_block(8, 3, 2, 11, 1'b0, 1'b0, 1'b1);
    run_block(8, 6, 3, 12, 1'b0, 1'b0, 1'b0);
    run_block(1, 2, 3, 13, 1'b0, 1'b0, 1'b0);
    run_block(8, 1, 0, 14, 1'b1, 1'b0, 1'b0);
    run_block(6, 4, 0, 15, 1'b1, 1'b0, 1'b1);
    run_block(8, 5, 0, 16, 1'b0, 1'b1, 1'b0);
    run_block(8, 0, 0, 17, 1'b0, 1'b1, 1'b1);
    run_block(3, 7, 0, 18, 1'b0, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule